// File: doc/BRIEF.md
# Streaming Job Sequencer with Independent Read and Write Address Counters

This block runs one job of an accelerator that sits between an input RAM and an output RAM. The host sets a job length on `size_i` and raises `go_i`. The block copies the length into a register. It then reads the input RAM at addresses 0 through length-1, one address per cycle. A read-valid flag goes along with each read. It is delayed by the one-cycle RAM read latency, so it lines up with the data that enters the pipeline.

A separate write counter handles the output side. It advances only in a cycle where the pipeline flags its result as valid. Each valid result is written to the output RAM at the next output address, starting from 0. Because of this, the sequencer never needs to know how deep the pipeline is, and bubbles in the pipeline do no harm.

After the last result has been written, `done_o` goes high. It stays high until the host drops `go_i`. A new job starts only when `go_i` is raised again after that.

Top module: `stream_job_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `done_o`, `rd_en_o`, `in_valid_o` and `wr_en_o` are all 0, even when `pipe_valid_i` is 1.
- R2: If `go_i` is 1 at a clock edge while the block is idle, a job starts. `rd_en_o` is 1 in the cycle that follows, unless the captured length is 0.
- R3: A job of length N produces exactly N read cycles, which are back to back. `rd_addr_o` runs 0, 1, …, N-1.
- R4: `in_valid_o` equals the value `rd_en_o` had one cycle earlier.
- R5: While a job runs, `wr_en_o` is 1 exactly in the cycles where `pipe_valid_i` is 1 and fewer than N results have been written. The k-th write (counting from 0) uses `wr_addr_o` = k. `wr_data_o` equals `pipe_data_i`, which is 17 bits wide.
- R6: `done_o` rises in the cycle after the N-th write.
- R7: `done_o` stays 1, with no reads and no writes, for as long as `go_i` stays 1. It falls in the cycle after `go_i` is sampled low.
- R8: A job of length 0 raises `done_o` in the cycle after the start, with no reads and no writes.
- R9: When no job is running (idle or done), `pipe_valid_i` causes no write.
- R10: Changing `size_i` after a job has started does not change that job's number of reads or writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go_i | input | 1 | Host start request, level |
| size_i | input | ADDR_W | Job length, copied when the job starts |
| done_o | output | 1 | Job complete, held until go_i falls |
| rd_addr_o | output | ADDR_W | Input RAM read address |
| rd_en_o | output | 1 | Input RAM read strobe |
| in_valid_o | output | 1 | Read data valid, entering the pipeline |
| pipe_valid_i | input | 1 | Pipeline result valid |
| pipe_data_i | input | OUT_W | Pipeline result |
| wr_addr_o | output | ADDR_W | Output RAM write address |
| wr_en_o | output | 1 | Output RAM write enable |
| wr_data_o | output | OUT_W | Output RAM write data |

## Verification
The hardest situation to reach from the ports is a job where results come back with gaps. Reads and writes are then far apart in time, and the write counter must skip the empty cycles while the read counter has already stopped.

The bench plays the part of an elastic pipeline. It counts the reads that went in, and it hands back the results under an 8-bit bubble mask, one mask per table entry. Sparse masks hold back the final writes until long after the last read. During the done phase, the bench keeps `pipe_valid_i` high on purpose, to show that the extra valids are ignored.

// File: rtl/sjc_pkg.sv
// Package: shared types for the streaming job sequencer.
// Assumes: nothing; holds only the controller state encoding.
package sjc_pkg;

    typedef enum logic [1:0] {
        SJC_IDLE = 2'd0,
        SJC_RUN  = 2'd1,
        SJC_DONE = 2'd2
    } sjc_state_e;

endpackage

// File: rtl/sjc_addr_gen.sv
// Module: up-counting address generator with a run-time limit.
// What it does: on clear_i it returns to 0. On step_i it advances while
//   the count is below limit_i. It flags when the count is active and when
//   the current address is the final one.
// Assumes: clear_i and step_i are never high in the same cycle.
module sjc_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] limit_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              active_o,
    output logic              last_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] cnt_q;

    // Count register: clear on a new job, advance on an accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i && active_o) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Status decode: still below the limit, and the final address reached.
    always_comb begin
        active_o = (cnt_q < limit_i);
        last_o   = active_o && (cnt_q == (limit_i - ONE));
    end

    assign addr_o = cnt_q;

endmodule

// File: rtl/sjc_valid_delay.sv
// Module: fixed delay line for a single valid bit.
// What it does: delays valid_i by LAT cycles; LAT = 0 passes it straight through.
// Assumes: reset clears every stage, so no stale valid survives a reset.
module sjc_valid_delay #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    output logic valid_o
);

    generate
        if (LAT == 0) begin : g_pass
            assign valid_o = valid_i;
        end else begin : g_pipe
            logic [LAT-1:0] stage_q;
            // Shift chain: each stage takes the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= {stage_q[LAT-1:0], valid_i} >> 0;
                end
            end
            assign valid_o = stage_q[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/sjc_fsm.sv
// Module: job controller state machine (idle, run, done).
// What it does: starts a job when go_i is seen in idle. It finishes on the
//   final write, or at once when the captured length is 0. It returns to idle
//   only after go_i has dropped.
// Assumes: wr_last_i is only high while a write is actually happening.
module sjc_fsm
    import sjc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       size_zero_i,
    input  logic       wr_last_i,
    output sjc_state_e state_o,
    output logic       start_o
);

    sjc_state_e state_q;
    sjc_state_e state_d;

    // Next-state logic for the job sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SJC_IDLE: if (go_i)      state_d = size_zero_i ? SJC_DONE : SJC_RUN;
            SJC_RUN:  if (wr_last_i) state_d = SJC_DONE;
            SJC_DONE: if (!go_i)     state_d = SJC_IDLE;
            default:                 state_d = SJC_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SJC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;
    assign start_o = (state_q == SJC_IDLE) && go_i;

endmodule

// File: rtl/stream_job_ctrl.sv
// Module: streaming job sequencer (top).
// What it does: captures the job length on start. It drives the input RAM
//   reads from address 0 and delays the read valid by the RAM latency. It
//   writes each valid pipeline result to consecutive output addresses, and
//   raises done after the final write.
// Assumes: the input RAM has RD_LAT cycles of read latency. The pipeline
//   returns results in order and never more of them than were read.
module stream_job_ctrl
    import sjc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OUT_W  = 17,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] size_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_en_o,
    output logic              in_valid_o,
    input  logic              pipe_valid_i,
    input  logic [OUT_W-1:0]  pipe_data_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_en_o,
    output logic [OUT_W-1:0]  wr_data_o
);

    sjc_state_e        state;
    logic              start;
    logic              running;
    logic [ADDR_W-1:0] size_q;
    logic              rd_active;
    logic              rd_last;
    logic              wr_active;
    logic              wr_last;

    // Job length register: copied from the host only when a job starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
        end else if (start) begin
            size_q <= size_i;
        end
    end

    sjc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go_i),
        .size_zero_i (size_i == '0),
        .wr_last_i   (wr_en_o && wr_last),
        .state_o     (state),
        .start_o     (start)
    );

    sjc_addr_gen #(.ADDR_W(ADDR_W)) u_rd_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start),
        .step_i   (rd_en_o),
        .limit_i  (size_q),
        .addr_o   (rd_addr_o),
        .active_o (rd_active),
        .last_o   (rd_last)
    );

    sjc_addr_gen #(.ADDR_W(ADDR_W)) u_wr_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start),
        .step_i   (wr_en_o),
        .limit_i  (size_q),
        .addr_o   (wr_addr_o),
        .active_o (wr_active),
        .last_o   (wr_last)
    );

    sjc_valid_delay #(.LAT(RD_LAT)) u_rd_vld (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (rd_en_o),
        .valid_o (in_valid_o)
    );

    // Strobe decode: reads run freely, writes wait for a pipeline valid.
    always_comb begin
        running   = (state == SJC_RUN);
        rd_en_o   = running && rd_active;
        wr_en_o   = running && wr_active && pipe_valid_i;
        wr_data_o = pipe_data_i;
        done_o    = (state == SJC_DONE);
    end

    logic unused_rd_last;
    assign unused_rd_last = rd_last;

endmodule

// File: rtl/stream_job_ctrl_chk.sv
// Module: assertion checker for stream_job_ctrl, attached with bind.
// What it does: checks, at the ports, the address sequencing, the valid
//   delay, the write gating and the done handshake.
// Assumes: rst_n is held low for at least two clock edges.
module stream_job_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              go_i,
    input logic              done_o,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              in_valid_o,
    input logic              pipe_valid_i,
    input logic              wr_en_o
);

    AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1))); // R3
    AST_RD_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en_o) |-> (rd_addr_o == '0)); // R3
    AST_IN_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_o == $past(rd_en_o)); // R4
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> pipe_valid_i); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && go_i) |=> done_o); // R7
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !go_i) |=> !done_o); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!wr_en_o && !rd_en_o)); // R9

endmodule

bind stream_job_ctrl stream_job_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go_i),
    .done_o       (done_o),
    .rd_en_o      (rd_en_o),
    .rd_addr_o    (rd_addr_o),
    .in_valid_o   (in_valid_o),
    .pipe_valid_i (pipe_valid_i),
    .wr_en_o      (wr_en_o)
);

// File: tb/stream_job_ctrl_tb.sv
module stream_job_ctrl_tb;

    localparam int ADDR_W = 16;
    localparam int OUT_W  = 17;
    localparam int NJOB   = 7;
    // Job table: length, bubble mask for returned results, expected writes.
    localparam int          T_SIZE [NJOB] = '{1, 4, 9, 16, 3, 2, 0};
    localparam logic [7:0]  T_MASK [NJOB] = '{8'hFF, 8'hAA, 8'h11, 8'hFF, 8'h80, 8'h01, 8'hFF};
    localparam int          T_EXPW [NJOB] = '{1, 4, 9, 16, 3, 2, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              go_i = 1'b0;
    logic [ADDR_W-1:0] size_i = '0;
    logic              done_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_en_o;
    logic              in_valid_o;
    logic              pipe_valid_i = 1'b0;
    logic [OUT_W-1:0]  pipe_data_i = '0;
    logic [ADDR_W-1:0] wr_addr_o;
    logic              wr_en_o;
    logic [OUT_W-1:0]  wr_data_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    stream_job_ctrl #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .RD_LAT(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .size_i(size_i), .done_o(done_o),
        .rd_addr_o(rd_addr_o), .rd_en_o(rd_en_o), .in_valid_o(in_valid_o),
        .pipe_valid_i(pipe_valid_i), .pipe_data_i(pipe_data_i),
        .wr_addr_o(wr_addr_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
    );

    function automatic logic [OUT_W-1:0] res_of(int k);
        return OUT_W'((k * 37 + 5) * 113);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_outputs(input string tag);
        chk(done_o == 1'b0, tag, int'(done_o), 0);
        chk(rd_en_o == 1'b0, tag, int'(rd_en_o), 0);
        chk(in_valid_o == 1'b0, tag, int'(in_valid_o), 0);
        chk(wr_en_o == 1'b0, tag, int'(wr_en_o), 0);
    endtask

    // One job: the bench acts as an elastic pipeline that returns results under a bubble mask.
    task automatic run_job(input int sz, input logic [7:0] mask, input int expw);
        int reads = 0;
        int pend = 0;
        int emit = 0;
        int cyc = 0;
        int last_wr = -1;
        logic prev_rd = 1'b0;
        bit fin = 1'b0;
        @(negedge clk);
        size_i = ADDR_W'(sz);
        go_i = 1'b1;
        pipe_valid_i = 1'b0;
        while (!fin && cyc < 3000) begin
            @(negedge clk);
            chk(in_valid_o == prev_rd, "R4 in_valid delay", int'(in_valid_o), int'(prev_rd));
            if (in_valid_o) pend++;
            prev_rd = rd_en_o;
            if (cyc == 0) begin
                chk(rd_en_o == (sz != 0), "R2 first read", int'(rd_en_o), int'(sz != 0));
                size_i = ADDR_W'(sz + 5); // R10: change length mid-job
            end
            if (rd_en_o) begin
                chk(rd_addr_o == ADDR_W'(reads), "R3 read address", int'(rd_addr_o), reads);
                reads++;
            end
            if (done_o) begin
                fin = 1'b1;
                chk(cyc == last_wr + 1, "R6 done timing", cyc, last_wr + 1);
            end else begin
                pipe_valid_i = (pend > 0) && mask[cyc % 8];
                pipe_data_i = res_of(emit);
                #1;
                chk(wr_en_o == pipe_valid_i, "R5 write gating", int'(wr_en_o), int'(pipe_valid_i));
                if (wr_en_o) begin
                    chk(wr_addr_o == ADDR_W'(emit), "R5 write address", int'(wr_addr_o), emit);
                    chk(wr_data_o == res_of(emit), "R5 write data", int'(wr_data_o), int'(res_of(emit)));
                    emit++;
                    pend--;
                    last_wr = cyc;
                end
            end
            cyc++;
        end
        chk(fin, "R6 done reached", int'(fin), 1);
        chk(reads == expw, "R3 R10 read count", reads, expw);
        chk(emit == expw, "R5 R10 write count", emit, expw);
        if (sz == 0) chk(reads + emit == 0, "R8 empty job", reads + emit, 0);
        // Hold go: done stays, extra valids are ignored.
        for (int h = 0; h < 3; h++) begin
            pipe_valid_i = 1'b1;
            #1;
            chk(wr_en_o == 1'b0, "R9 write in done", int'(wr_en_o), 0);
            chk(done_o == 1'b1, "R7 done held", int'(done_o), 1);
            chk(rd_en_o == 1'b0, "R7 no restart", int'(rd_en_o), 0);
            @(negedge clk);
        end
        go_i = 1'b0;
        pipe_valid_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done release", int'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, with a valid pushed at the pipeline input.
        pipe_valid_i = 1'b1;
        go_i = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        idle_outputs("R1 in reset");
        go_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        idle_outputs("R1 after reset");
        // R9: valids while idle cause no write.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(wr_en_o == 1'b0, "R9 write in idle", int'(wr_en_o), 0);
        end
        pipe_valid_i = 1'b0;

        for (int j = 0; j < NJOB; j++) begin
            run_job(T_SIZE[j], T_MASK[j], T_EXPW[j]);
        end

        // R1: reset in the middle of a job.
        @(negedge clk);
        size_i = 16'd10;
        go_i = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        go_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        idle_outputs("R1 mid-job reset");
        rst_n = 1'b1;
        @(negedge clk);
        run_job(2, 8'hFF, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule